// File: doc/BRIEF.md
# Tape FSK Byte Receiver

This block turns a squared-up cassette signal into bytes. Each input transition ends a half-period. The block counts the system-clock cycles between transitions and sorts each half-period into one of three kinds: fast (high tone), slow (low tone), or too long to be either. Two slow half-periods, which make one low-frequency cycle, give a 0 bit. Four fast half-periods, which make two high-frequency cycles, give a single 1 bit. The second fast cycle is absorbed and never produces a bit of its own.

A frame decoder takes the resulting bit stream and applies asynchronous-serial framing: a 0 start bit, eight data bits with the least significant first, and a 1 stop bit. A 1 is the resting level of the line. A good frame places its byte on `rxData` and raises `rxFull`, which stays set until the host pulses `byteRead`. Alongside the frame decoder, a run counter watches for ten 1 bits in a row. Framed data can never contain such a run, so the block treats it as leader tone. It then raises `highTone` and gives a one-cycle `toneIrq` pulse. The host clears `highTone` with `toneAck`. `rxEnable` follows the tape motor: while it is low the decoder stays in its reset state.

Top module: `tape_fsk_rx`

## Requirements
- R1: Each half-period is measured in system-clock cycles between two successive input transitions. A half-period shorter than THRESH is fast. One of at least THRESH and less than MAX_HALF is slow. Two successive slow half-periods decode as one 0 bit.
- R2: Four successive fast half-periods (two fast cycles) decode as exactly one 1 bit. The second fast cycle is consumed and produces no bit, including within the stop bit.
- R3: After a 0 start bit, the next eight bits are collected with the least significant bit first. A 1 in the tenth position copies the byte to `rxData` and sets `rxFull`.
- R4: A 0 in the stop position discards the frame. `rxData` and `rxFull` keep their previous values, and the decoder goes back to waiting for a 1.
- R5: While waiting for a 1, 0 bits are ignored. A single 1 bit is enough to start the search for a start bit. After a good stop bit the decoder goes straight to that search, so frames may follow one another with no gap.
- R6: A `byteRead` pulse clears `rxFull`. If a byte is loaded in the same cycle, the load wins.
- R7: The tenth successive 1 bit sets `highTone` and pulses `toneIrq` high for one cycle. Nine successive 1 bits do neither. A run raises the flag at most once, however long it lasts.
- R8: Any 0 bit restarts the run count. `toneAck` clears `highTone`; if a detection happens in the same cycle, the detection wins.
- R9: While `rxEnable` is low, the half-period pairing, the frame decoder and the run count are held cleared. Any half-period of MAX_HALF cycles or more is discarded and restarts the pairing; this includes the first one after enabling. `rxData`, `rxFull` and `highTone` are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxEnable | input | 1 | Motor-on receive enable |
| tapeIn | input | 1 | Squared tape signal, asynchronous |
| byteRead | input | 1 | Host read strobe, clears `rxFull` |
| toneAck | input | 1 | Host strobe, clears `highTone` |
| rxData | output | 8 | Last byte received |
| rxFull | output | 1 | A received byte is waiting |
| highTone | output | 1 | Leader tone detected |
| toneIrq | output | 1 | One-cycle pulse when leader tone is detected |

## Verification
The hardest situation to reach is the run-length boundary of the tone detector. It must stay quiet on nine ones and fire on the tenth, and it must see a 0 bit reset the run even when that bit is the start bit of a frame. The bench reaches the nine-one case naturally during an exhaustive sweep of all 256 bytes sent back to back: byte 0xFF followed by its stop bit forms the longest legal run. It then builds runs bit by bit after a disable, first splitting a run with a frame of zeros and then extending a fresh run one bit past nine.

// File: rtl/fskrx_pkg.sv
package fskrx_pkg;

  // Half-period classification produced by the datapath
  typedef struct packed {
    logic halfShort;
    logic halfLong;
    logic halfBad;
  } halfEvt_t;

  // Strobes from control into the datapath
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadByte;
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_DATA,
    ST_STOP
  } frameSt_t;

endpackage

// File: rtl/fskrx_datapath.sv
module fskrx_datapath
  import fskrx_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int THRESH   = 5000,
  parameter int MAX_HALF = 10000,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxEnable,
  input  logic              tapeIn,
  input  dpCtl_t            ctl,
  output halfEvt_t          evt,
  output logic [DATA_W-1:0] rxData
);

  localparam logic [CNT_W-1:0] THR_C = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_HALF);

  logic [2:0]        syncQ;
  logic              edgeSeen;
  logic [CNT_W-1:0]  halfCnt;
  logic [DATA_W-1:0] shiftReg;

  // Two synchronising flops plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[1:0], tapeIn};
  end

  assign edgeSeen = syncQ[2] ^ syncQ[1];

  // Interval counter: cleared on each edge, saturates, held full when off
  always_ff @(posedge clk) begin
    if (rst || !rxEnable)  halfCnt <= '1;
    else if (edgeSeen)     halfCnt <= '0;
    else if (halfCnt != '1) halfCnt <= halfCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt <= '0;
    end else begin
      evt.halfShort <= rxEnable && edgeSeen && (halfCnt < THR_C);
      evt.halfLong  <= rxEnable && edgeSeen && (halfCnt >= THR_C) && (halfCnt < MAX_C);
      evt.halfBad   <= rxEnable && edgeSeen && (halfCnt >= MAX_C);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      rxData   <= '0;
    end else begin
      if (ctl.shiftEn)  shiftReg <= {ctl.shiftBit, shiftReg[DATA_W-1:1]};
      if (ctl.loadByte) rxData   <= shiftReg;
    end
  end

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    ctl.loadByte |=> rxData == $past(shiftReg)); // R3

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt.halfShort, evt.halfLong, evt.halfBad})); // R1

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !rxEnable |=> evt == '0); // R9

endmodule

// File: rtl/fskrx_control.sv
module fskrx_control
  import fskrx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TONE_RUN = 10
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     rxEnable,
  input  halfEvt_t evt,
  input  logic     byteRead,
  input  logic     toneAck,
  output dpCtl_t   ctl,
  output logic     rxFull,
  output logic     highTone,
  output logic     toneIrq
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int RUN_W = $clog2(TONE_RUN + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(TONE_RUN);
  localparam logic [RUN_W-1:0] RUN_HIT  = RUN_W'(TONE_RUN - 1);

  logic             longSeen;
  logic [1:0]       shortCnt;
  logic             bitValid;
  logic             bitVal;
  frameSt_t         state;
  logic [IDX_W-1:0] bitIdx;
  logic [RUN_W-1:0] runCnt;
  logic             toneHit;

  // Half-period pairing into bits
  assign bitValid = (evt.halfLong && longSeen) || (evt.halfShort && shortCnt == 2'd3);
  assign bitVal   = evt.halfShort;

  always_ff @(posedge clk) begin
    if (rst || !rxEnable || evt.halfBad) begin
      longSeen <= 1'b0;
      shortCnt <= '0;
    end else if (evt.halfLong) begin
      shortCnt <= '0;
      longSeen <= !longSeen;
    end else if (evt.halfShort) begin
      longSeen <= 1'b0;
      shortCnt <= shortCnt + 2'd1;
    end
  end

  // Frame decoder
  assign ctl.shiftEn  = bitValid && (state == ST_DATA);
  assign ctl.shiftBit = bitVal;
  assign ctl.loadByte = bitValid && (state == ST_STOP) && bitVal;

  always_ff @(posedge clk) begin
    if (rst || !rxEnable) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else if (bitValid) begin
      case (state)
        ST_IDLE: if (bitVal) state <= ST_HUNT;
        ST_HUNT: if (!bitVal) begin
          state  <= ST_DATA;
          bitIdx <= '0;
        end
        ST_DATA: begin
          bitIdx <= bitIdx + 1'b1;
          if (bitIdx == LAST_IDX) state <= ST_STOP;
        end
        default: state <= bitVal ? ST_HUNT : ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               rxFull <= 1'b0;
    else if (ctl.loadByte) rxFull <= 1'b1;
    else if (byteRead)     rxFull <= 1'b0;
  end

  // Leader tone run detector
  assign toneHit = bitValid && bitVal && (runCnt == RUN_HIT);

  always_ff @(posedge clk) begin
    if (rst || !rxEnable) runCnt <= '0;
    else if (bitValid) begin
      if (!bitVal)              runCnt <= '0;
      else if (runCnt != RUN_MAX) runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      highTone <= 1'b0;
      toneIrq  <= 1'b0;
    end else begin
      toneIrq <= toneHit;
      if (toneHit)      highTone <= 1'b1;
      else if (toneAck) highTone <= 1'b0;
    end
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    byteRead && !ctl.loadByte |=> !rxFull); // R6

  AST_LOAD_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(rxFull) |-> $past(state) == ST_STOP); // R3

  AST_TONE_SET: assert property (@(posedge clk) disable iff (rst)
    toneHit |=> highTone && toneIrq); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    toneIrq |=> !toneIrq); // R7

  AST_ZERO_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
    bitValid && !bitVal && rxEnable |=> runCnt == '0); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    toneAck && !toneHit |=> !highTone); // R8

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !rxEnable |=> state == ST_IDLE && runCnt == '0); // R9

endmodule

// File: rtl/tape_fsk_rx.sv
module tape_fsk_rx
  import fskrx_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int THRESH   = 5000,
  parameter int MAX_HALF = 10000,
  parameter int DATA_W   = 8,
  parameter int TONE_RUN = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxEnable,
  input  logic              tapeIn,
  input  logic              byteRead,
  input  logic              toneAck,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              highTone,
  output logic              toneIrq
);

  halfEvt_t evt;
  dpCtl_t   ctl;

  fskrx_datapath #(
    .CNT_W(CNT_W), .THRESH(THRESH), .MAX_HALF(MAX_HALF), .DATA_W(DATA_W)
  ) i_datapath (
    .clk(clk), .rst(rst), .rxEnable(rxEnable), .tapeIn(tapeIn),
    .ctl(ctl), .evt(evt), .rxData(rxData)
  );

  fskrx_control #(
    .DATA_W(DATA_W), .TONE_RUN(TONE_RUN)
  ) i_control (
    .clk(clk), .rst(rst), .rxEnable(rxEnable), .evt(evt),
    .byteRead(byteRead), .toneAck(toneAck), .ctl(ctl),
    .rxFull(rxFull), .highTone(highTone), .toneIrq(toneIrq)
  );

endmodule

// File: tb/test_tape_fsk_rx.sv
`timescale 1ns/1ps
module test_tape_fsk_rx;

  localparam int FAST = 6;
  localparam int SLOW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxEnable = 1'b0;
  logic tapeIn = 1'b0;
  logic byteReadTask = 1'b0;
  logic byteReadAuto = 1'b0;
  logic byteRead;
  logic toneAck = 1'b0;
  logic [7:0] rxData;
  logic rxFull, highTone, toneIrq;

  int checks = 0;
  int errors = 0;
  int irqCnt = 0;
  logic autoRead = 1'b0;
  logic [7:0] capQ [256];
  int capN = 0;
  logic done = 1'b0;

  assign byteRead = byteReadTask | byteReadAuto;

  always #2.5 clk = ~clk;

  tape_fsk_rx #(.CNT_W(16), .THRESH(9), .MAX_HALF(20), .DATA_W(8), .TONE_RUN(10)) i_tape_fsk_rx (
    .clk(clk), .rst(rst), .rxEnable(rxEnable), .tapeIn(tapeIn),
    .byteRead(byteRead), .toneAck(toneAck), .rxData(rxData),
    .rxFull(rxFull), .highTone(highTone), .toneIrq(toneIrq)
  );

  always @(posedge clk) if (!rst && toneIrq) irqCnt <= irqCnt + 1;

  always @(negedge clk) begin
    if (byteReadAuto) byteReadAuto <= 1'b0;
    else if (autoRead && rxFull) begin
      if (capN < 256) capQ[capN] <= rxData;
      capN <= capN + 1;
      byteReadAuto <= 1'b1;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic halfWave(int n);
    waitCyc(n);
    tapeIn = ~tapeIn;
  endtask

  task automatic prime();
    @(negedge clk);
    tapeIn = ~tapeIn;
  endtask

  task automatic sendBit(bit b);
    if (b) repeat (4) halfWave(FAST);
    else   repeat (2) halfWave(SLOW);
  endtask

  task automatic sendOnes(int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic sendFrame(logic [7:0] d, bit stopBit);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit(stopBit);
  endtask

  task automatic pauseLine();
    waitCyc(40);
  endtask

  task automatic readByte();
    @(negedge clk); byteReadTask = 1'b1;
    @(negedge clk); byteReadTask = 1'b0;
  endtask

  task automatic restartEnable();
    @(negedge clk); rxEnable = 1'b0;
    waitCyc(5);
    rxEnable = 1'b1;
  endtask

  initial begin
    int irqBase;
    waitCyc(4);
    rst = 1'b0;
    waitCyc(2);
    // reset state
    check("R3 reset rxFull", rxFull, 0);
    check("R7 reset highTone", highTone, 0);
    check("R7 reset toneIrq", toneIrq, 0);
    check("R3 reset rxData", rxData, 0);

    // R5: 0 bits before any 1 are ignored; zeros frame with stop 1 loads nothing
    rxEnable = 1'b1;
    prime(); sendFrame(8'h00, 1'b1); pauseLine();
    check("R5 no leader no load", rxFull, 0);

    // R3: basic frame, LSB first (decoder now searching for start)
    prime(); sendFrame(8'hA5, 1'b1); pauseLine();
    check("R3 full after frame", rxFull, 1);
    check("R3 byte value", rxData, 8'hA5);

    // R6: read clears full
    readByte(); waitCyc(1);
    check("R6 read clears", rxFull, 0);

    // R4: stop bit 0 discards
    prime(); sendFrame(8'h3C, 1'b0); pauseLine();
    check("R4 discard full", rxFull, 0);
    check("R4 discard data kept", rxData, 8'hA5);

    // R5: after discard a single 1 re-arms
    prime(); sendBit(1'b1); sendFrame(8'h5A, 1'b1); pauseLine();
    check("R5 single one rearms", rxData, 8'h5A);
    check("R5 full", rxFull, 1);
    readByte();

    // R9: disable mid-frame, state dropped, data kept
    prime(); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    restartEnable(); pauseLine();
    check("R9 no load from cut frame", rxFull, 0);
    check("R9 data kept", rxData, 8'h5A);
    prime(); sendFrame(8'h00, 1'b1); pauseLine();
    check("R9 idle after enable", rxFull, 0);
    prime(); sendBit(1'b1); sendFrame(8'hC3, 1'b1); pauseLine();
    check("R9 frame after enable", rxData, 8'hC3);
    readByte();

    // R1 R2 R3 R5: exhaustive back-to-back byte sweep
    autoRead = 1'b1;
    prime(); sendBit(1'b1);
    for (int v = 0; v < 256; v++) sendFrame(v[7:0], 1'b1);
    pauseLine();
    autoRead = 1'b0;
    waitCyc(2);
    check("R5 back-to-back count", capN, 256);
    for (int v = 0; v < 256; v++) check("R1 R2 R3 sweep byte", capQ[v], v);
    // longest legal run (0xFF + stop) is nine ones
    check("R7 nine ones no tone", highTone, 0);

    // R8: a 0 bit restarts the run
    restartEnable();
    prime(); sendOnes(5); sendFrame(8'h00, 1'b1); sendOnes(8); pauseLine();
    check("R8 zero restarts run", highTone, 0);
    check("R8 no irq", irqCnt, 0);
    readByte();

    // R7: the tenth one fires, once
    prime(); sendOnes(1); pauseLine();
    check("R7 tenth one sets", highTone, 1);
    check("R7 irq pulsed", irqCnt, 1);
    prime(); sendOnes(5); pauseLine();
    check("R7 single raise per run", irqCnt, 1);

    // R8: ack clears; longer run does not re-raise
    @(negedge clk); toneAck = 1'b1;
    @(negedge clk); toneAck = 1'b0;
    waitCyc(1);
    check("R8 ack clears", highTone, 0);
    prime(); sendOnes(3); pauseLine();
    check("R8 stays clear in same run", highTone, 0);
    irqBase = irqCnt;
    prime(); sendFrame(8'hFF, 1'b1); sendOnes(1); pauseLine();
    check("R7 new run after zero raises", highTone, 1);
    check("R7 one more pulse", irqCnt, irqBase + 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule